// File: doc/BRIEF.md
# Dual Four-Output Addressable Latch

This block holds two banks of four storage bits each. Both banks share one 2-bit address and two active-low controls, an enable and a clear. Each bank has its own single data input. The two controls together pick one of four modes. In addressable-write mode one bit per bank is written and the other bits keep their values. In hold mode nothing changes. In demultiplex mode each bank routes its data bit to the addressed output and drives the other three outputs low. In clear mode all outputs go low.

The block is fully synchronous. Controls, address and data are sampled on the rising edge of the system clock, and the registered outputs show the result right after that edge. An asynchronous active-low reset zeroes all storage and is independent of the functional clear. A usage rule applies to the address. It may change in more than one bit between samples only when the block is not in addressable-write mode. A bound checker flags any violation of this rule.

Top module: `dual_addr_latch`

## Requirements
- R1: While rst_ni is low, all eight outputs are zero, with no clock edge needed.
- R2: Mode is decoded from (en_ni, clr_ni). With en_ni=1 and clr_ni=0 (clear), all outputs are zero after the next rising edge.
- R3: With en_ni=0 and clr_ni=0 (demultiplex), each bank's output bit at the address equals that bank's data after the edge. Its other three bits are zero.
- R4: With en_ni=0 and clr_ni=1 (addressable write), each bank's addressed bit takes that bank's data. Its other three bits keep their previous values.
- R5: With en_ni=1 and clr_ni=1 (hold), outputs are unchanged whatever the data and address inputs do.
- R6: The address is binary with addr_i[0] as LSB. Value k (0..3) selects output bit k of each bank.
- R7: The banks share address and controls but hold independent data. d_a_i affects only q_a_o, and d_b_i affects only q_b_o.
- R8: Outputs are registered. Inputs applied between edges show no effect until the next rising edge, and they show it immediately after that edge.
- R9: The address may change in several bits at once only outside addressable-write mode. In that case no stored bit is disturbed. Between two consecutive addressable-write samples, the address differs in at most one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_ni | input | 1 | Enable, active low |
| clr_ni | input | 1 | Functional clear, active low |
| addr_i | input | 2 | Shared bit address, bit 0 is LSB |
| d_a_i | input | 1 | Data for bank a |
| d_b_i | input | 1 | Data for bank b |
| q_a_o | output | 4 | Bank a outputs |
| q_b_o | output | 4 | Bank b outputs |

## Verification
The bench targets several corner cases. The first is the difference between demultiplex and addressable write: a design that kept unaddressed bits in demultiplex mode would leave stale ones on the outputs. The second is a two-bit address jump made in hold mode: a design that wrote during hold would corrupt a stored bit. The third is bank independence under opposite data, which catches crossed or shared data paths. The last is the one-edge latency: a combinational path would change outputs before the edge, and an extra pipeline stage would change them one edge late.

// File: rtl/alatch_pkg.sv
package alatch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } alatch_mode_e;
endpackage

// File: rtl/alatch_mode_dec.sv
module alatch_mode_dec
  import alatch_pkg::*;
(
  input  logic         en_ni,
  input  logic         clr_ni,
  output alatch_mode_e mode_o
);
  always_comb begin
    unique case ({en_ni, clr_ni})
      2'b01:   mode_o = MODE_WRITE;
      2'b11:   mode_o = MODE_HOLD;
      2'b00:   mode_o = MODE_DEMUX;
      default: mode_o = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/alatch_bank.sv
module alatch_bank
  import alatch_pkg::*;
#(
  parameter  int ADDR_W = 2,
  localparam int WIDTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  alatch_mode_e      mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              d_i,
  output logic [WIDTH-1:0]  q_o
);
  logic [WIDTH-1:0] sel;
  logic [WIDTH-1:0] q_d, q_q;

  always_comb begin
    sel = '0;
    sel[addr_i] = 1'b1;
  end

  always_comb begin
    unique case (mode_i)
      MODE_CLEAR: q_d = '0;
      MODE_DEMUX: q_d = sel & {WIDTH{d_i}};
      MODE_WRITE: q_d = (q_q & ~sel) | (sel & {WIDTH{d_i}});
      default:    q_d = q_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/dual_addr_latch.sv
module dual_addr_latch
  import alatch_pkg::*;
#(
  parameter  int ADDR_W = 2,
  localparam int WIDTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_ni,
  input  logic              clr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              d_a_i,
  input  logic              d_b_i,
  output logic [WIDTH-1:0]  q_a_o,
  output logic [WIDTH-1:0]  q_b_o
);
  localparam int NUM_BANKS = 2;

  alatch_mode_e         mode;
  logic [NUM_BANKS-1:0] d_bank;
  logic [WIDTH-1:0]     q_bank [NUM_BANKS];

  assign d_bank = {d_b_i, d_a_i};

  alatch_mode_dec u_mode_dec (
    .en_ni  (en_ni),
    .clr_ni (clr_ni),
    .mode_o (mode)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    alatch_bank #(.ADDR_W(ADDR_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode),
      .addr_i (addr_i),
      .d_i    (d_bank[b]),
      .q_o    (q_bank[b])
    );
  end

  assign q_a_o = q_bank[0];
  assign q_b_o = q_bank[1];
endmodule

// File: rtl/dual_addr_latch_chk.sv
module dual_addr_latch_chk #(
  parameter  int ADDR_W = 2,
  localparam int WIDTH  = 1 << ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_ni,
  input logic              clr_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              d_a_i,
  input logic              d_b_i,
  input logic [WIDTH-1:0]  q_a_o,
  input logic [WIDTH-1:0]  q_b_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R2
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(en_ni) && !$past(clr_ni)) |-> (q_a_o == '0 && q_b_o == '0));

  // R3
  demux_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(en_ni) && !$past(clr_ni)) |->
      (q_a_o == (WIDTH'($past(d_a_i)) << $past(addr_i)) &&
       q_b_o == (WIDTH'($past(d_b_i)) << $past(addr_i))));

  // R4
  write_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(en_ni) && $past(clr_ni)) |->
      (q_a_o[$past(addr_i)] == $past(d_a_i) && q_b_o[$past(addr_i)] == $past(d_b_i)));

  // R4
  write_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(en_ni) && $past(clr_ni)) |->
      ((((q_a_o ^ $past(q_a_o)) | (q_b_o ^ $past(q_b_o))) &
        ~(WIDTH'(1) << $past(addr_i))) == '0));

  // R5
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(en_ni) && $past(clr_ni)) |-> ($stable(q_a_o) && $stable(q_b_o)));

  // R9
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !en_ni && clr_ni && !$past(en_ni) && $past(clr_ni)) |->
      ($countones(addr_i ^ $past(addr_i)) <= 1));
endmodule

bind dual_addr_latch dual_addr_latch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_ni  (en_ni),
  .clr_ni (clr_ni),
  .addr_i (addr_i),
  .d_a_i  (d_a_i),
  .d_b_i  (d_b_i),
  .q_a_o  (q_a_o),
  .q_b_o  (q_b_o)
);

// File: tb/dual_addr_latch_bench.sv
module dual_addr_latch_bench;
  localparam int ADDR_W = 2;
  localparam int WIDTH  = 1 << ADDR_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_ni = 1'b1, clr_ni = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic d_a_i = 1'b0, d_b_i = 1'b0;
  logic [WIDTH-1:0] q_a_o, q_b_o;

  int errors = 0;
  int checks = 0;

  always #2.5ns clk_i = ~clk_i;

  dual_addr_latch #(.ADDR_W(ADDR_W)) u_dual_addr_latch (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_ni (en_ni), .clr_ni (clr_ni),
    .addr_i (addr_i), .d_a_i (d_a_i), .d_b_i (d_b_i),
    .q_a_o (q_a_o), .q_b_o (q_b_o)
  );

  typedef struct packed {
    logic       en_n;
    logic       clr_n;
    logic [1:0] addr;
    logic       da;
    logic       db;
    logic [3:0] qa;
    logic [3:0] qb;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 4'b0001, 4'b0000},
    '{1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 4'b0001, 4'b0010},
    '{1'b0, 1'b1, 2'd3, 1'b1, 1'b1, 4'b1001, 4'b1010},
    '{1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 4'b1101, 4'b1010},
    '{1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 4'b1101, 4'b1010},
    '{1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'b1101, 4'b1010},
    '{1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 4'b1100, 4'b1011},
    '{1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 4'b0100, 4'b0000},
    '{1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 4'b0010, 4'b0010},
    '{1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 4'b0000, 4'b1000},
    '{1'b0, 1'b1, 2'd3, 1'b1, 1'b0, 4'b1000, 4'b0000},
    '{1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 4'b1010, 4'b0010},
    '{1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 4'b0000, 4'b0000},
    '{1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 4'b0000, 4'b0001},
    '{1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 4'b0000, 4'b0001}
  };

  task automatic check(input string req, input logic [3:0] exp_a, input logic [3:0] exp_b);
    checks++;
    if (q_a_o !== exp_a || q_b_o !== exp_b) begin
      errors++;
      $display("FAIL %s: q_a=%b q_b=%b expected q_a=%b q_b=%b", req, q_a_o, q_b_o, exp_a, exp_b);
    end
  endtask

  task automatic drive(input logic en, input logic clr, input logic [1:0] a,
                       input logic da, input logic db);
    en_ni = en; clr_ni = clr; addr_i = a; d_a_i = da; d_b_i = db;
  endtask

  function automatic string mode_req(input logic en, input logic clr);
    if (en && !clr) return "R2 clear";
    if (!en && !clr) return "R3 demux";
    if (!en && clr) return "R4 write";
    return "R5 hold";
  endfunction

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5ns);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset held", 4'b0000, 4'b0000);
    rst_ni = 1'b1;

    // vector table: drive at negedge, result visible after next posedge
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].en_n, VECS[i].clr_n, VECS[i].addr, VECS[i].da, VECS[i].db);
      @(negedge clk_i);
      check(mode_req(VECS[i].en_n, VECS[i].clr_n), VECS[i].qa, VECS[i].qb);
      if (i == 4) check("R9 multi-bit jump in hold", 4'b1101, 4'b1010);
    end

    // R6: walk address in demux mode, one-hot bit k
    for (int k = 0; k < WIDTH; k++) begin
      drive(1'b0, 1'b0, 2'(k), 1'b1, 1'b1);
      @(negedge clk_i);
      check("R6 address bit order", 4'(1 << k), 4'(1 << k));
    end

    // R7: opposite data per bank, same address
    drive(1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
    @(negedge clk_i);
    drive(1'b0, 1'b1, 2'd2, 1'b1, 1'b0);
    @(negedge clk_i);
    check("R7 bank a only", 4'b0100, 4'b0000);
    drive(1'b0, 1'b1, 2'd2, 1'b0, 1'b1);
    @(negedge clk_i);
    check("R7 bank b only", 4'b0000, 4'b0100);

    // R5: hold ignores toggling data and address over several edges
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, 1'b1, 2'(3 - k), k[0], ~k[0]);
      @(negedge clk_i);
      check("R5 hold toggling inputs", 4'b0000, 4'b0100);
    end

    // R8: no change before the edge, change right after it
    drive(1'b0, 1'b1, 2'd3, 1'b1, 1'b1);
    #1ns;
    check("R8 before edge", 4'b0000, 4'b0100);
    @(posedge clk_i);
    #0.5ns;
    check("R8 after edge", 4'b1000, 4'b1100);

    // R1: asynchronous reset mid-cycle
    @(negedge clk_i);
    drive(1'b1, 1'b1, 2'd0, 1'b0, 1'b0);
    #0.5ns;
    rst_ni = 1'b0;
    #0.5ns;
    check("R1 async reset", 4'b0000, 4'b0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 state after reset", 4'b0000, 4'b0000);

    finish_run();
  end
endmodule